// File: doc/BRIEF.md
# Multi-Source Wakeup Event Controller

This block gathers wakeup requests from six sources and turns them into one wakeup request for the power sequencer. Two sources are internal voltage-detect event lines, which are already synchronous to the block clock. The other four are external wake pins, which are asynchronous and pass through a two-flop synchronizer first. Each source has an enable bit, a trigger polarity bit (rising or falling) and a sticky pending flag.

Software sets up the block through a small register port with a single-cycle write and a combinational read. The voltage-detect enables and the pin enables sit in two separate registers, so that writing one group leaves the other group unchanged. All six polarity bits sit in one register, so one write sets every source's trigger edge. Pending flags are read from a fourth register and are cleared by writing 1 to each flag bit that is to be cleared. The wakeup output is high whenever any flag is pending.

Source index i is used in every per-source field: index 0 is voltage detect 1, index 1 is voltage detect 2, and indices 2 to 5 are wake pins 0 to 3.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After reset, all four registers read zero and `wake_o` is low.
- R2: Address 0 holds the voltage-detect enables in bits [1:0]. Address 1 holds the pin enables in bits [3:0]. Writing one of these registers leaves the other unchanged, and unused bits read 0.
- R3: Address 2 holds the polarity bits in bits [5:0], with bit i for source i. A value of 1 selects the rising edge and 0 selects the falling edge. One write updates all six bits.
- R4: Address 3 bit i reads the pending flag of source i. A flag stays set after its source returns to its idle level.
- R5: A flag is set only when its source is enabled and the source shows the edge its polarity bit selects. The opposite edge, or any edge on a disabled source, leaves the flag unchanged.
- R6: A write to address 3 clears every flag whose data bit is 1 and leaves flags with a 0 data bit unchanged. If a qualifying edge arrives in the same cycle as the clear, the flag stays set.
- R7: `wake_o` is high exactly when at least one flag is set.
- R8: A pin change is seen as flagged after the third rising clock edge following the change. A voltage-detect change is seen as flagged after the first rising clock edge.
- R9: Reads of unused addresses return 0. Writes to unused addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vd_evt | input | 2 | Synchronous voltage-detect event levels |
| pin_in | input | 4 | Asynchronous wake pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| wake_o | output | 1 | Combined wakeup request |

## Verification
The bench aims at three timing cases. It checks the exact cycle in which a pin edge becomes a flag, so an extra or missing synchronizer stage shows up as a flag one cycle late or early. It checks a clear that lands in the same cycle as a new edge, which would drop a wakeup if the clear were given priority over the set. It checks that a falling-edge selection ignores rising edges, which catches an inverted polarity bit, and that a disabled pin never flags. A write to one enable register must not disturb the other, and an unused address must stay inert. A long random phase compares every flag and the wakeup output against a reference model on every cycle.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam logic [2:0] ADR_EN_VD  = 3'd0;
    localparam logic [2:0] ADR_EN_PIN = 3'd1;
    localparam logic [2:0] ADR_POL    = 3'd2;
    localparam logic [2:0] ADR_FLAG   = 3'd3;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.pipe[STAGES-1];
endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] hit
);
    typedef struct packed {
        logic [N-1:0] prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        logic up, down;
        assign up     = level[g] & ~st_q.prev[g];
        assign down   = ~level[g] & st_q.prev[g];
        assign hit[g] = rise_sel[g] ? up : down;
    end
endmodule

// File: rtl/wake_flag_bank.sv
module wake_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] flag
);
    typedef struct packed {
        logic [N-1:0] pend;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new event outranks a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.pend;
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
    import wake_pkg::*;
#(
    parameter int NVD  = 2,
    parameter int NPIN = 4,
    parameter int AW   = 3,
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NVD-1:0]  vd_evt,
    input  logic [NPIN-1:0] pin_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            wake_o
);
    localparam int NSRC = NVD + NPIN;

    typedef struct packed {
        logic [NPIN-1:0] en_pin;
        logic [NVD-1:0]  en_vd;
        logic [NSRC-1:0] pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [NPIN-1:0] pin_sync;
    logic [NSRC-1:0] level_vec;
    logic [NSRC-1:0] hit_vec;
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] flag_vec;

    wake_sync #(.W(NPIN), .STAGES(SYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    assign level_vec = {pin_sync, vd_evt};

    wake_edge #(.N(NSRC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level_vec),
        .rise_sel(cfg_q.pol),
        .hit     (hit_vec)
    );

    assign en_vec  = {cfg_q.en_pin, cfg_q.en_vd};
    assign set_vec = hit_vec & en_vec;
    assign clr_vec = (wr_en && wr_addr == AW'(ADR_FLAG)) ? wr_data[NSRC-1:0] : '0;

    wake_flag_bank #(.N(NSRC)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set_v(set_vec),
        .clr_v(clr_vec),
        .flag (flag_vec)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == AW'(ADR_EN_VD))       cfg_d.en_vd  = wr_data[NVD-1:0];
            else if (wr_addr == AW'(ADR_EN_PIN)) cfg_d.en_pin = wr_data[NPIN-1:0];
            else if (wr_addr == AW'(ADR_POL))    cfg_d.pol    = wr_data[NSRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADR_EN_VD))       rd_data[NVD-1:0]  = cfg_q.en_vd;
        else if (rd_addr == AW'(ADR_EN_PIN)) rd_data[NPIN-1:0] = cfg_q.en_pin;
        else if (rd_addr == AW'(ADR_POL))    rd_data[NSRC-1:0] = cfg_q.pol;
        else if (rd_addr == AW'(ADR_FLAG))   rd_data[NSRC-1:0] = flag_vec;
    end

    assign wake_o = |flag_vec;
endmodule

// File: rtl/wake_evt_ctrl_chk.sv
module wake_evt_ctrl_chk #(
    parameter int N  = 6,
    parameter int AW = 3,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  flag,
    input logic [N-1:0]  hit,
    input logic [N-1:0]  en,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wake
);
    logic [N-1:0] clr_mask;
    assign clr_mask = (wr_en && wr_addr == AW'(3)) ? wr_data[N-1:0] : '0;

    // R5: a newly raised flag needs an enabled source and a qualifying edge
    a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag & ~$past(flag) & ~$past(en & hit)) == '0));

    // R4: a pending flag falls only when its bit was written with 1
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flag) & ~flag & ~$past(clr_mask)) == '0));

    // R6: cleared bits with no edge that cycle read zero afterwards
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((flag & $past(clr_mask & ~(en & hit))) == '0));

    // R7: the wakeup output rises only together with a new flag
    a_r7_wake_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> ((flag & ~$past(flag)) != '0));
endmodule

bind wake_evt_ctrl wake_evt_ctrl_chk #(.N(NSRC), .AW(AW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag   (flag_vec),
    .hit    (hit_vec),
    .en     (en_vec),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wake   (wake_o)
);

// File: tb/tb_wake_evt_ctrl.sv
module tb_wake_evt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] vd_evt = '0;
    logic [3:0] pin_in = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wake_o;

    int total = 0;
    int fails = 0;

    wake_evt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .vd_evt(vd_evt), .pin_in(pin_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wake_o(wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic [1:0] m_vd_prev;
    logic [3:0] m_s1, m_s2, m_pin_prev;
    logic [5:0] m_en, m_pol, m_flag;

    function automatic logic [5:0] edge_hits(logic [5:0] cur, logic [5:0] prv, logic [5:0] pol);
        logic [5:0] h;
        for (int i = 0; i < 6; i++)
            h[i] = pol[i] ? (cur[i] & ~prv[i]) : (~cur[i] & prv[i]);
        return h;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_vd_prev = '0; m_s1 = '0; m_s2 = '0; m_pin_prev = '0;
            m_en = '0; m_pol = '0; m_flag = '0;
        end else begin
            logic [5:0] set_m, clr_m;
            set_m = edge_hits({m_s2, vd_evt}, {m_pin_prev, m_vd_prev}, m_pol) & m_en;
            clr_m = (wr_en && wr_addr == 3'd3) ? wr_data[5:0] : 6'd0;
            m_flag = (m_flag & ~clr_m) | set_m;
            if (wr_en && wr_addr == 3'd0) m_en[1:0] = wr_data[1:0];
            if (wr_en && wr_addr == 3'd1) m_en[5:2] = wr_data[3:0];
            if (wr_en && wr_addr == 3'd2) m_pol = wr_data[5:0];
            m_pin_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_vd_prev = vd_evt;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=%0d expected=done", WD_CYCLES);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), v); chk("R1 reset reg", v, 0);
        end
        chk("R1 reset wake", wake_o, 0);

        // R2 separate enable registers
        wr(3'd0, 8'hFF);
        rd(3'd0, v); chk("R2 vd enable", v, 8'h03);
        rd(3'd1, v); chk("R2 pin enable untouched", v, 8'h00);
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R2 pin enable", v, 8'h0F);
        wr(3'd0, 8'h00);
        rd(3'd1, v); chk("R2 pin enable kept", v, 8'h0F);
        rd(3'd0, v); chk("R2 vd enable cleared", v, 8'h00);

        // R3 polarity register
        wr(3'd2, 8'hFF);
        rd(3'd2, v); chk("R3 pol all", v, 8'h3F);
        wr(3'd2, 8'h15);
        rd(3'd2, v); chk("R3 pol pattern", v, 8'h15);

        // R9 unused address
        wr(3'd5, 8'hFF);
        rd(3'd5, v); chk("R9 unused read", v, 0);
        rd(3'd2, v); chk("R9 pol unchanged", v, 8'h15);
        rd(3'd1, v); chk("R9 pin en unchanged", v, 8'h0F);

        // R8/R5 pin 0 rising (source 2), pin 1 falling (source 3)
        wr(3'd1, 8'h03);
        wr(3'd2, 8'h04);
        pin_in[0] = 1'b1;
        tick(); rd(3'd3, v); chk("R8 pin not yet after 1", v[2], 0);
        tick(); rd(3'd3, v); chk("R8 pin not yet after 2", v[2], 0);
        tick(); rd(3'd3, v); chk("R8 pin flagged after 3", v[2], 1);
        chk("R7 wake high", wake_o, 1);
        pin_in[0] = 1'b0;
        wait_n(4);
        rd(3'd3, v); chk("R4 flag sticky", v, 8'h04);

        pin_in[1] = 1'b1;
        wait_n(4);
        rd(3'd3, v); chk("R5 rising ignored on falling select", v[3], 0);
        pin_in[1] = 1'b0;
        wait_n(3);
        rd(3'd3, v); chk("R5 falling edge flagged", v[3], 1);

        // R5 disabled pin 3 (source 5)
        pin_in[3] = 1'b1; wait_n(4); pin_in[3] = 1'b0; wait_n(4);
        rd(3'd3, v); chk("R5 disabled source", v[5], 0);

        // R6 write-one-to-clear
        wr(3'd3, 8'h04);
        rd(3'd3, v); chk("R6 partial clear", v, 8'h08);
        wr(3'd3, 8'h3F);
        rd(3'd3, v); chk("R6 full clear", v, 8'h00);
        chk("R7 wake low", wake_o, 0);

        // R8 voltage detect latency and R6 set beats clear
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h01);
        vd_evt[0] = 1'b1;
        tick(); rd(3'd3, v); chk("R8 vd flagged after 1", v[0], 1);
        vd_evt[0] = 1'b0;
        tick();
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 8'h01; vd_evt[0] = 1'b1;
        tick(); wr_en = 1'b0;
        rd(3'd3, v); chk("R6 set wins over clear", v[0], 1);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(0, 7) == 0) pin_in[$urandom_range(0, 3)] ^= 1'b1;
            if ($urandom_range(0, 5) == 0) vd_evt[$urandom_range(0, 1)] ^= 1'b1;
            if ($urandom_range(0, 9) == 0) begin
                wr_en = 1'b1; wr_addr = 3'($urandom_range(0, 5)); wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            tick();
            rd(3'd3, v); chk("R5/R6 random flags", v, {2'b0, m_flag});
            chk("R7 random wake", wake_o, |m_flag);
            if (c % 32 == 0) begin
                rd(3'd0, v); chk("R2 random vd en", v, {6'b0, m_en[1:0]});
                rd(3'd1, v); chk("R2 random pin en", v, {4'b0, m_en[5:2]});
                rd(3'd2, v); chk("R3 random pol", v, {2'b0, m_pol});
            end
        end
        wr_en = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule